// File: doc/BRIEF.md
# Bignum Accelerator Host Control Registers

This block is the register front end that a host processor uses to drive a big-number arithmetic engine. The host programs four operand vector pointers, two operand lengths and a shift amount. It then writes an operation code with the run bit set. The block copies the programmed parameters into a working set that faces the datapath and issues a one-cycle start pulse. It keeps the run bit high until the datapath reports completion with a one-cycle done pulse carrying a three-bit compare outcome. The interrupt output is high whenever the engine is idle.

While an operation is in flight, the host may already program pointers and lengths for the next operation. Those writes land in the host-visible copy only, and the working set stays untouched until the next start. The operation code and the shift amount are frozen while the run bit is set. A stall-result bit lets software delay the completion: results that arrive while it is set are parked, and they are committed one cycle after software clears the bit. The start/done pair is plain control signalling with no back-pressure. The datapath must accept every start pulse, and the block takes a done pulse only while an operation is running.

Top module: `bignum_host_ctl`

## Requirements
- R1: After reset the run bit reads 1 and stays 1 for INIT_CYCLES clock cycles after reset is released (default 4). After that it reads 0 with no host action.
- R2: Each operand pointer register (word addresses 0 to 3 for vectors A to D) stores bits [10:1] of the written data. Stored bit 0 is always 0, and bits above 10 read as 0.
- R3: The length registers (addresses 4 and 5) keep the low 9 written bits. The shift register (address 6) keeps the low 5 written bits. Upper bits read as 0.
- R4: A write to the function register (address 7) with bit 15 set while the run bit is 0 sets the run bit. In the next cycle `op_start` is high for exactly one cycle, and `op_func` shows written bits [11:0].
- R5: At a start, the working pointers, lengths and shift take the values then held in the host-visible registers. Pointer and length writes made while running update only the host-visible copy, and the working values change only at the next start.
- R6: While the run bit is 1, writes to the function operation bits [11:0] and to the shift register are ignored. A write with bit 15 set produces no new start, and host writes never clear the run bit.
- R7: With stall-result at 0, a `dp_done` pulse during a running operation clears the run bit at that clock edge. The compare register (address 8) loads `dp_cmp` at the same edge: bit 2 means A greater than B, bit 1 means A less than B, bit 0 means equal.
- R8: Stall-result is function bit 24 and is writable at any time. If it is 1 when `dp_done` arrives, the run bit stays 1 and the compare register keeps its value. One cycle after a write returns the bit to 0, the parked outcome is loaded and the run bit clears.
- R9: `idle_irq` is always the complement of the run bit.
- R10: The function register reads back with the operation bits in [11:0], run in bit 15, stall-result in bit 24 and zeros elsewhere. The compare register uses bits [2:0]. Addresses 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| op_start | output | 1 | One-cycle start pulse to the datapath |
| op_func | output | 12 | Working operation bits |
| op_a_ptr | output | 11 | Working pointer to vector A |
| op_b_ptr | output | 11 | Working pointer to vector B |
| op_c_ptr | output | 11 | Working pointer to vector C |
| op_d_ptr | output | 11 | Working pointer to vector D |
| op_a_len | output | 9 | Working length of A in 32-bit words |
| op_b_len | output | 9 | Working length of B in 32-bit words |
| op_shift | output | 5 | Working shift amount |
| dp_done | input | 1 | One-cycle completion pulse from the datapath |
| dp_cmp | input | 3 | Compare outcome delivered with dp_done |
| idle_irq | output | 1 | High while no operation is running |

## Verification
The hardest state to reach is a parked completion: an operation must be started with stall-result already set, the done pulse must arrive while stalled, and the release write must then be observed on both sides of the edge that commits it. The bench reaches this with a start write that sets bits 15 and 24 together, injects the done pulse, and then writes the function register with only the stall bit cleared. It reads the run bit and the compare register directly after the release write and again one cycle later. The double-buffering path is reached by reprogramming a pointer inside every operation of a sweep over all twelve operation bits, so each start also checks the value programmed during the previous run.

// File: rtl/bignum_ctl_pkg.sv
package bignum_ctl_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 4;
  localparam int OP_W        = 12;
  localparam int CMP_W       = 3;
  localparam int RUN_BIT     = 15;
  localparam int STALL_BIT   = 24;

  typedef enum logic [ADDR_W-1:0] {
    RA_APTR  = 4'd0,
    RA_BPTR  = 4'd1,
    RA_CPTR  = 4'd2,
    RA_DPTR  = 4'd3,
    RA_ALEN  = 4'd4,
    RA_BLEN  = 4'd5,
    RA_SHIFT = 4'd6,
    RA_FUNC  = 4'd7,
    RA_CMP   = 4'd8
  } reg_addr_e;

  typedef enum logic [1:0] {
    SQ_INIT,
    SQ_IDLE,
    SQ_BUSY,
    SQ_HOLD
  } seq_state_e;
endpackage

// File: rtl/bignum_ctl_regfile.sv
module bignum_ctl_regfile
  import bignum_ctl_pkg::*;
#(
  parameter int PTR_W = 11,
  parameter int LEN_W = 9,
  parameter int SH_W  = 5,
  parameter int NPTR  = 4,
  parameter int NLEN  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [OP_W-1:0]       wr_data,
  input  logic                  run,
  input  logic                  start_go,
  output logic [PTR_W-1:0]      stg_ptr [NPTR],
  output logic [PTR_W-1:0]      act_ptr [NPTR],
  output logic [LEN_W-1:0]      stg_len [NLEN],
  output logic [LEN_W-1:0]      act_len [NLEN],
  output logic [SH_W-1:0]       stg_shift,
  output logic [SH_W-1:0]       act_shift,
  output logic [OP_W-1:0]       stg_op,
  output logic [OP_W-1:0]       act_op
);
  localparam logic [ADDR_W-1:0] PTR_BASE = RA_APTR;
  localparam logic [ADDR_W-1:0] LEN_BASE = RA_ALEN;

  // host-visible copies; pointers and lengths stay writable while running
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPTR; i++) stg_ptr[i] <= '0;
      for (int i = 0; i < NLEN; i++) stg_len[i] <= '0;
      stg_shift <= '0;
      stg_op    <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NPTR; i++)
        if (wr_addr == PTR_BASE + ADDR_W'(i))
          stg_ptr[i] <= {wr_data[PTR_W-1:1], 1'b0};
      for (int i = 0; i < NLEN; i++)
        if (wr_addr == LEN_BASE + ADDR_W'(i))
          stg_len[i] <= wr_data[LEN_W-1:0];
      if (wr_addr == RA_SHIFT && !run) stg_shift <= wr_data[SH_W-1:0];
      if (wr_addr == RA_FUNC && !run)  stg_op    <= wr_data;
    end
  end

  // working set seen by the datapath, loaded only at a start
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPTR; i++) act_ptr[i] <= '0;
      for (int i = 0; i < NLEN; i++) act_len[i] <= '0;
      act_shift <= '0;
      act_op    <= '0;
    end else if (start_go) begin
      for (int i = 0; i < NPTR; i++) act_ptr[i] <= stg_ptr[i];
      for (int i = 0; i < NLEN; i++) act_len[i] <= stg_len[i];
      act_shift <= stg_shift;
      act_op    <= wr_data;
    end
  end
endmodule

// File: rtl/bignum_ctl_seq.sv
module bignum_ctl_seq
  import bignum_ctl_pkg::*;
#(
  parameter int INIT_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fn_wr,
  input  logic             wr_run,
  input  logic             wr_stall,
  input  logic             dp_done,
  input  logic [CMP_W-1:0] dp_cmp,
  output logic             run,
  output logic             stall,
  output logic             start_go,
  output logic [CMP_W-1:0] cmp_q
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] init_cnt;
  logic [CMP_W-1:0] cmp_pend;

  assign run      = (state != SQ_IDLE);
  assign start_go = fn_wr && wr_run && (state == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) stall <= 1'b0;
    else if (fn_wr) stall <= wr_stall;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_INIT;
      init_cnt <= '0;
      cmp_pend <= '0;
      cmp_q    <= '0;
    end else begin
      unique case (state)
        SQ_INIT: begin
          if (init_cnt == CNT_LAST) state <= SQ_IDLE;
          else init_cnt <= init_cnt + 1'b1;
        end
        SQ_IDLE: begin
          if (start_go) state <= SQ_BUSY;
        end
        SQ_BUSY: begin
          if (dp_done) begin
            if (stall) begin
              cmp_pend <= dp_cmp;
              state    <= SQ_HOLD;
            end else begin
              cmp_q <= dp_cmp;
              state <= SQ_IDLE;
            end
          end
        end
        SQ_HOLD: begin
          if (!stall) begin
            cmp_q <= cmp_pend;
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_INIT;
      endcase
    end
  end
endmodule

// File: rtl/bignum_host_ctl.sv
module bignum_host_ctl
  import bignum_ctl_pkg::*;
#(
  parameter int PTR_W       = 11,
  parameter int LEN_W       = 9,
  parameter int SH_W        = 5,
  parameter int INIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              op_start,
  output logic [OP_W-1:0]   op_func,
  output logic [PTR_W-1:0]  op_a_ptr,
  output logic [PTR_W-1:0]  op_b_ptr,
  output logic [PTR_W-1:0]  op_c_ptr,
  output logic [PTR_W-1:0]  op_d_ptr,
  output logic [LEN_W-1:0]  op_a_len,
  output logic [LEN_W-1:0]  op_b_len,
  output logic [SH_W-1:0]   op_shift,
  input  logic              dp_done,
  input  logic [CMP_W-1:0]  dp_cmp,
  output logic              idle_irq
);
  localparam int NPTR = 4;
  localparam int NLEN = 2;

  logic             fn_wr;
  logic             seq_run;
  logic             seq_stall;
  logic             start_go;
  logic [CMP_W-1:0] seq_cmp;
  logic [PTR_W-1:0] stg_ptr [NPTR];
  logic [PTR_W-1:0] act_ptr [NPTR];
  logic [LEN_W-1:0] stg_len [NLEN];
  logic [LEN_W-1:0] act_len [NLEN];
  logic [SH_W-1:0]  stg_shift;
  logic [OP_W-1:0]  stg_op;

  assign fn_wr = reg_wr && (reg_addr == RA_FUNC);

  bignum_ctl_regfile #(
    .PTR_W(PTR_W), .LEN_W(LEN_W), .SH_W(SH_W), .NPTR(NPTR), .NLEN(NLEN)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata[OP_W-1:0]),
    .run      (seq_run),
    .start_go (start_go),
    .stg_ptr  (stg_ptr),
    .act_ptr  (act_ptr),
    .stg_len  (stg_len),
    .act_len  (act_len),
    .stg_shift(stg_shift),
    .act_shift(op_shift),
    .stg_op   (stg_op),
    .act_op   (op_func)
  );

  bignum_ctl_seq #(
    .INIT_CYCLES(INIT_CYCLES)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .fn_wr   (fn_wr),
    .wr_run  (reg_wdata[RUN_BIT]),
    .wr_stall(reg_wdata[STALL_BIT]),
    .dp_done (dp_done),
    .dp_cmp  (dp_cmp),
    .run     (seq_run),
    .stall   (seq_stall),
    .start_go(start_go),
    .cmp_q   (seq_cmp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) op_start <= 1'b0;
    else op_start <= start_go;
  end

  assign op_a_ptr = act_ptr[0];
  assign op_b_ptr = act_ptr[1];
  assign op_c_ptr = act_ptr[2];
  assign op_d_ptr = act_ptr[3];
  assign op_a_len = act_len[0];
  assign op_b_len = act_len[1];
  assign idle_irq = ~seq_run;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_APTR:  reg_rdata[PTR_W-1:0] = stg_ptr[0];
      RA_BPTR:  reg_rdata[PTR_W-1:0] = stg_ptr[1];
      RA_CPTR:  reg_rdata[PTR_W-1:0] = stg_ptr[2];
      RA_DPTR:  reg_rdata[PTR_W-1:0] = stg_ptr[3];
      RA_ALEN:  reg_rdata[LEN_W-1:0] = stg_len[0];
      RA_BLEN:  reg_rdata[LEN_W-1:0] = stg_len[1];
      RA_SHIFT: reg_rdata[SH_W-1:0]  = stg_shift;
      RA_FUNC: begin
        reg_rdata[OP_W-1:0]  = stg_op;
        reg_rdata[RUN_BIT]   = seq_run;
        reg_rdata[STALL_BIT] = seq_stall;
      end
      RA_CMP:   reg_rdata[CMP_W-1:0] = seq_cmp;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bignum_host_ctl_chk.sv
module bignum_host_ctl_chk #(
  parameter int PTR_W = 11,
  parameter int OP_W  = 12,
  parameter int CMP_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_start,
  input logic             idle_irq,
  input logic [PTR_W-1:0] op_a_ptr,
  input logic [OP_W-1:0]  op_func,
  input logic             stall,
  input logic [CMP_W-1:0] cmp_q
);
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(idle_irq)); // R4
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start); // R4
  AST_RUN_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !idle_irq); // R9
  AST_WORKING_SET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_start |-> ($stable(op_a_ptr) && $stable(op_func))); // R5
  AST_STALL_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !idle_irq) |=> !idle_irq); // R8
  AST_CMP_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_q) |-> $rose(idle_irq)); // R7
endmodule

bind bignum_host_ctl bignum_host_ctl_chk #(
  .PTR_W(PTR_W), .OP_W(12), .CMP_W(3)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_start(op_start),
  .idle_irq(idle_irq),
  .op_a_ptr(op_a_ptr),
  .op_func (op_func),
  .stall   (seq_stall),
  .cmp_q   (seq_cmp)
);

// File: tb/tb_bignum_host_ctl.sv
module tb_bignum_host_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_CYC   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        op_start;
  logic [11:0] op_func;
  logic [10:0] op_a_ptr, op_b_ptr, op_c_ptr, op_d_ptr;
  logic [8:0]  op_a_len, op_b_len;
  logic [4:0]  op_shift;
  logic        dp_done = 1'b0;
  logic [2:0]  dp_cmp = '0;
  logic        idle_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bignum_host_ctl #(.INIT_CYCLES(INIT_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .op_start(op_start),
    .op_func(op_func), .op_a_ptr(op_a_ptr), .op_b_ptr(op_b_ptr),
    .op_c_ptr(op_c_ptr), .op_d_ptr(op_d_ptr), .op_a_len(op_a_len),
    .op_b_len(op_b_len), .op_shift(op_shift), .dp_done(dp_done),
    .dp_cmp(dp_cmp), .idle_irq(idle_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic run_bit(output logic r);
    logic [31:0] d;
    bus_rd(4'd7, d); r = d[15];
  endtask

  task automatic pulse_done(input logic [2:0] c);
    dp_done = 1'b1; dp_cmp = c;
    @(posedge clk); @(negedge clk);
    dp_done = 1'b0; dp_cmp = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic r;
    logic [10:0] exp_ptr [4];
    logic [8:0]  exp_alen, exp_blen;
    logic [4:0]  exp_sh;
    logic [31:0] vals [5];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: run high straight after reset, clears by itself later
    run_bit(r); chk("R1 run after reset", {31'b0, r}, 32'd1);
    chk("R9 irq during init", {31'b0, idle_irq}, 32'd0);
    chk("R4 no start after reset", {31'b0, op_start}, 32'd0);
    repeat (INIT_CYC + 3) @(negedge clk);
    run_bit(r); chk("R1 run clears after init", {31'b0, r}, 32'd0);
    chk("R9 irq idle", {31'b0, idle_irq}, 32'd1);

    // R2 / R3: masking sweeps
    vals[0] = 32'h0; vals[1] = 32'hFFFF_FFFF; vals[2] = 32'h0000_0555;
    vals[3] = 32'h0000_02AA; vals[4] = 32'h1234_5679;
    for (int a = 0; a < 4; a++)
      for (int v = 0; v < 5; v++) begin
        bus_wr(4'(a), vals[v] + 32'(a));
        bus_rd(4'(a), d);
        chk("R2 pointer readback", d, (vals[v] + 32'(a)) & 32'h7FE);
      end
    for (int a = 4; a < 7; a++)
      for (int v = 0; v < 5; v++) begin
        bus_wr(4'(a), vals[v] ^ 32'(a));
        bus_rd(4'(a), d);
        chk("R3 length/shift readback", d, (vals[v] ^ 32'(a)) & ((a == 6) ? 32'h1F : 32'h1FF));
      end
    // R10: unmapped addresses read zero
    for (int a = 9; a < 16; a++) begin
      bus_rd(4'(a), d); chk("R10 unmapped read", d, 32'h0);
    end

    // R4..R7 sweep over every operation bit
    for (int k = 0; k < 12; k++) begin
      for (int p = 0; p < 4; p++) begin
        exp_ptr[p] = 11'((k * 64 + p * 200 + 2) & 32'h7FE);
        bus_wr(4'(p), 32'(exp_ptr[p]));
      end
      exp_alen = 9'(k * 37 + 1); exp_blen = 9'(500 - k * 11); exp_sh = 5'(k * 3);
      bus_wr(4'd4, 32'(exp_alen));
      bus_wr(4'd5, 32'(exp_blen));
      bus_wr(4'd6, 32'(exp_sh));
      bus_wr(4'd7, 32'h0000_8000 | (32'd1 << k));
      chk("R4 start pulse", {31'b0, op_start}, 32'd1);
      chk("R4 op_func", {20'b0, op_func}, 32'd1 << k);
      chk("R5 working pointers", {op_a_ptr, op_b_ptr, op_c_ptr, op_d_ptr},
          {exp_ptr[0], exp_ptr[1], exp_ptr[2], exp_ptr[3]});
      chk("R5 working lengths/shift", {op_a_len, op_b_len, op_shift},
          {exp_alen, exp_blen, exp_sh});
      chk("R9 irq while running", {31'b0, idle_irq}, 32'd0);
      bus_rd(4'd7, d); chk("R10 function readback", d, 32'h0000_8000 | (32'd1 << k));
      @(negedge clk);
      chk("R4 start is one cycle", {31'b0, op_start}, 32'd0);
      // R6: locked fields
      bus_wr(4'd6, 32'(~exp_sh));
      bus_rd(4'd6, d); chk("R6 shift locked", d, 32'(exp_sh));
      bus_wr(4'd7, 32'h0000_8000 | (32'd1 << ((k + 5) % 12)));
      chk("R6 no restart", {31'b0, op_start}, 32'd0);
      bus_rd(4'd7, d); chk("R6 op bits locked", d, 32'h0000_8000 | (32'd1 << k));
      bus_wr(4'd7, 32'h0);
      run_bit(r); chk("R6 host cannot clear run", {31'b0, r}, 32'd1);
      // R5: shadow write while running
      bus_wr(4'd0, 32'h0000_0100);
      bus_rd(4'd0, d); chk("R5 shadow readback", d, 32'h100);
      chk("R5 working pointer kept", {21'b0, op_a_ptr}, 32'(exp_ptr[0]));
      chk("R5 working shift kept", {27'b0, op_shift}, 32'(exp_sh));
      // R7: completion without stall
      pulse_done(3'(1 << (k % 3)));
      run_bit(r); chk("R7 run cleared on done", {31'b0, r}, 32'd0);
      chk("R9 irq after done", {31'b0, idle_irq}, 32'd1);
      bus_rd(4'd8, d); chk("R7 compare captured", d, 32'd1 << (k % 3));
      // start again to see the shadowed pointer taken up
      bus_wr(4'd7, 32'h0000_8001);
      chk("R5 shadow taken at start", {21'b0, op_a_ptr}, 32'h100);
      pulse_done(3'(1 << (k % 3)));
    end

    // R8: stall set at start, done arrives while stalled (previous compare = 4)
    bus_wr(4'd7, 32'h0100_8001);
    pulse_done(3'b010);
    run_bit(r); chk("R8 run held by stall", {31'b0, r}, 32'd1);
    bus_rd(4'd8, d); chk("R8 compare not updated", d, 32'd4);
    repeat (3) @(negedge clk);
    run_bit(r); chk("R8 still held", {31'b0, r}, 32'd1);
    chk("R9 irq while held", {31'b0, idle_irq}, 32'd0);
    bus_rd(4'd7, d); chk("R10 stall bit readback", d, 32'h0100_8001);
    bus_wr(4'd7, 32'h0);
    run_bit(r); chk("R8 run at release edge", {31'b0, r}, 32'd1);
    bus_rd(4'd8, d); chk("R8 compare at release edge", d, 32'd4);
    @(negedge clk);
    run_bit(r); chk("R8 run cleared after release", {31'b0, r}, 32'd0);
    bus_rd(4'd8, d); chk("R8 parked compare committed", d, 32'd2);
    chk("R9 irq after release", {31'b0, idle_irq}, 32'd1);

    // R8: stall released before done behaves like a plain completion
    bus_wr(4'd7, 32'h0100_8002);
    bus_wr(4'd7, 32'h0);
    run_bit(r); chk("R8 running after early release", {31'b0, r}, 32'd1);
    pulse_done(3'b001);
    run_bit(r); chk("R7 run cleared after early release", {31'b0, r}, 32'd0);
    bus_rd(4'd8, d); chk("R7 compare equal", d, 32'd1);

    // R7: done while idle has no effect
    pulse_done(3'b100);
    bus_rd(4'd8, d); chk("R7 idle done ignored", d, 32'd1);
    run_bit(r); chk("R7 idle done keeps run low", {31'b0, r}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule